// File: doc/BRIEF.md
# Threshold Fan Speed PWM Controller

This block drives a cooling fan from one PWM output. Two 32-bit registers set the waveform in raw clock cycles: one holds the period and the other holds the high time. A small word-addressed bus writes and reads them. The period and high-time values the counter uses are reloaded only when a period wraps, so a register write never makes a shortened or stretched pulse.

On top of the waveform registers there is a three-level speed selector. Each time the external timer strobes `tick`, the block compares the latest 12-bit temperature reading with a low threshold and a high threshold, and picks level 1, 2 or 3. It then reloads the high-time register with one third, two thirds or all of the period. The host can also force a level through the control word. This sets an override flag that freezes automatic selection until the host releases it. Temperatures are read as unsigned integers, one degree per LSB. The defaults are 20 for the low threshold and 50 for the high threshold.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: Word address 0 is the period register, read/write. Its reset value is the parameter `RST_PERIOD`.
- R2: Word address 1 is the high-time register, read/write. Its reset value is `RST_PERIOD/3`, the integer quotient.
- R3: In steady state, every PWM period of P cycles contains exactly min(H, P) high cycles, where H is the high time. If H >= P and P >= 1, the output stays high. If H = 0, the output stays low.
- R4: A new period or high-time value first takes effect at the start of the next PWM period. The period already running completes with the old values.
- R5: After reset the speed level is 1 and the override flag is 0. Word address 2 holds the thresholds: low in bits [11:0] and high in bits [27:16]. They reset to 20 and 50 and are read/write.
- R6: On a cycle with `tick` high while override is 0, the level becomes 1 if the temperature is below the low threshold. Otherwise it becomes 3 if the temperature is at or above the high threshold. Otherwise it becomes 2.
- R7: Every automatic or manual level load also writes floor(period*level/3) into the high-time register, using the period register's current value. A bus write to address 1 in the same cycle takes priority over this load.
- R8: Word address 3 is the control word. Reading it returns the level in bits [1:0] and the override flag in bit 2. Writing it with bit 3 = 0 and bits [1:0] = 1..3 sets that level and sets the override flag.
- R9: While override is 1, ticks do not change the level. Writing the control word with bit 3 = 1 clears the override flag and leaves the level unchanged.
- R10: A control write with bit 3 = 0 and bits [1:0] = 0 has no effect.
- R11: The level changes only on a tick or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| temp | input | TW | Latest temperature reading |
| tick | input | 1 | Timer strobe, one cycle |
| speed | output | 2 | Current speed level (1..3) |
| override | output | 1 | Manual override flag |
| pwm_out | output | 1 | Fan PWM drive |

## Verification
A wrong level decision shows up on `speed` and in the high-time readback one cycle after the tick. That is why each tick in the temperature sweep is checked at the next sample point, on both sides of each threshold. A corrupted counter or reload path shows up as a wrong number of high cycles in a window of whole periods. It can also show as a pulse that changes in the middle of a period, so the duty is counted across three periods and again around a write placed inside a running period. An override flag stuck in the wrong state is caught by the next tick: the level either moves when it must hold, or holds when it must move.

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl #(
  parameter int W          = 32,
  parameter int TW         = 12,
  parameter int RST_PERIOD = 4000,
  parameter int LOW_DEF    = 20,
  parameter int HIGH_DEF   = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [TW-1:0] temp,
  input  logic          tick,
  output logic [1:0]    speed,
  output logic          override,
  output logic          pwm_out
);
  localparam int HI_LSB    = 16;
  localparam int RST_PULSE = RST_PERIOD / 3;

  logic [W-1:0]  period_q, pulse_q, act_period, act_pulse, cnt;
  logic [TW-1:0] lo_q, hi_q;
  logic [1:0]    speed_q;
  logic          ovr_q;

  wire wr_per = bus_wr && bus_addr == 2'd0;
  wire wr_pul = bus_wr && bus_addr == 2'd1;
  wire wr_thr = bus_wr && bus_addr == 2'd2;
  wire wr_ctl = bus_wr && bus_addr == 2'd3;

  wire       manual   = wr_ctl && !bus_wdata[3] && bus_wdata[1:0] != 2'd0;
  wire       release_ = wr_ctl && bus_wdata[3];
  wire [1:0] auto_lvl = (temp < lo_q) ? 2'd1 : (temp >= hi_q) ? 2'd3 : 2'd2;
  wire       auto_go  = tick && !ovr_q && !manual;
  wire       load_lvl = manual || auto_go;
  wire [1:0] next_lvl = manual ? bus_wdata[1:0] : auto_lvl;

  function automatic logic [W-1:0] scale(input logic [W-1:0] p, input logic [1:0] l);
    logic [W+1:0] m;
    m = {2'b00, p} * {{W{1'b0}}, l};
    return W'(m / (W+2)'(3));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= W'(RST_PERIOD);
      pulse_q  <= W'(RST_PULSE);
      lo_q     <= TW'(LOW_DEF);
      hi_q     <= TW'(HIGH_DEF);
      speed_q  <= 2'd1;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_per) period_q <= bus_wdata;
      if (wr_pul) pulse_q <= bus_wdata;
      else if (load_lvl) pulse_q <= scale(period_q, next_lvl);
      if (wr_thr) begin
        lo_q <= bus_wdata[TW-1:0];
        hi_q <= bus_wdata[HI_LSB +: TW];
      end
      if (load_lvl) speed_q <= next_lvl;
      if (manual) ovr_q <= 1'b1;
      else if (release_) ovr_q <= 1'b0;
    end
  end

  wire [W:0] cnt_nx = {1'b0, cnt} + 1'b1;
  wire       wrap   = cnt_nx >= {1'b0, act_period};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      act_period <= W'(RST_PERIOD);
      act_pulse  <= W'(RST_PULSE);
    end else if (wrap) begin
      cnt        <= '0;
      act_period <= period_q;
      act_pulse  <= pulse_q;
    end else begin
      cnt <= cnt_nx[W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = period_q;
      2'd1:    bus_rdata = pulse_q;
      2'd2:    bus_rdata = {{(W-HI_LSB-TW){1'b0}}, hi_q, {(HI_LSB-TW){1'b0}}, lo_q};
      default: bus_rdata = {{(W-3){1'b0}}, ovr_q, speed_q};
    endcase
  end

  assign pwm_out  = cnt < act_pulse;
  assign speed    = speed_q;
  assign override = ovr_q;
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic         tick,
  input logic [1:0]   speed,
  input logic         override,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_period,
  input logic [W-1:0] act_pulse
);
  wire ctl_wr = bus_wr && bus_addr == 2'd3;

  assert_speed_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    speed != 2'd0);

  assert_speed_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_wr) |=> $stable(speed));

  assert_override_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (override && !ctl_wr) |=> $stable(speed) && override);

  assert_reload_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_period) || !$stable(act_pulse)) |-> cnt == '0);

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < act_period) || (act_period == '0 && cnt == '0));
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .tick(tick),
  .speed(speed), .override(override), .cnt(cnt),
  .act_period(act_period), .act_pulse(act_pulse)
);

// File: tb/fan_pwm_ctrl_tb.sv
module fan_pwm_ctrl_tb;
  localparam int W = 32, TW = 12, RP = 12;

  logic clk = 0, rst_n = 0, bus_wr = 0, tick = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  logic [TW-1:0] temp = 0;
  logic [1:0] speed;
  logic override, pwm_out;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.W(W), .TW(TW), .RST_PERIOD(RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .temp(temp), .tick(tick),
    .speed(speed), .override(override), .pwm_out(pwm_out));

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output longint v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwm_out); end
  endtask

  task automatic do_tick(input int t);
    temp = TW'(t); tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  function automatic int lvl(input int t, input int lo, input int hi);
    if (t < lo) return 1;
    if (t >= hi) return 3;
    return 2;
  endfunction

  longint v;
  int h;
  int per;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, v); chk("R1 reset period", v, RP);
    rd(2'd1, v); chk("R2 reset pulse", v, RP/3);
    rd(2'd2, v); chk("R5 reset thresholds", v, (50 << 16) | 20);
    rd(2'd3, v); chk("R5 reset ctl", v, 1);
    highs(3*RP, h); chk("R3 reset duty", h, 3*(RP/3));

    for (int t = 0; t <= 60; t++) begin
      do_tick(t);
      chk("R6 auto level", speed, lvl(t, 20, 50));
      rd(2'd1, v); chk("R7 pulse from level", v, (RP*lvl(t, 20, 50))/3);
    end
    do_tick(4095); chk("R6 max temp", speed, 3);

    wr(2'd2, (32'd11 << 16) | 32'd10);
    rd(2'd2, v); chk("R5 threshold write", v, (11 << 16) | 10);
    for (int t = 0; t <= 15; t++) begin
      do_tick(t);
      chk("R6 narrow band", speed, lvl(t, 10, 11));
    end

    for (int p = 1; p <= 8; p++) begin
      for (int q = 0; q <= 9; q++) begin
        wr(2'd0, W'(p)); wr(2'd1, W'(q));
        rd(2'd0, v); chk("R1 period rw", v, p);
        rd(2'd1, v); chk("R2 pulse rw", v, q);
        repeat (30) @(negedge clk);
        highs(3*p, h);
        chk("R3 duty window", h, 3*((q < p) ? q : p));
      end
    end

    wr(2'd0, W'(RP)); wr(2'd2, (32'd50 << 16) | 32'd20);
    wr(2'd3, 32'd2);
    chk("R8 manual level", speed, 2);
    rd(2'd3, v); chk("R8 ctl readback", v, 6);
    rd(2'd1, v); chk("R7 manual pulse", v, (RP*2)/3);
    do_tick(60); chk("R9 tick ignored", speed, 2);
    wr(2'd3, 32'd0);
    rd(2'd3, v); chk("R10 zero write ignored", v, 6);
    repeat (20) @(negedge clk);
    chk("R11 idle hold", speed, 2);
    wr(2'd3, 32'd8);
    rd(2'd3, v); chk("R9 release", v, 2);
    do_tick(60); chk("R6 auto after release", speed, 3);
    rd(2'd1, v); chk("R7 full pulse", v, RP);
    wr(2'd3, 32'd1); chk("R8 manual level 1", speed, 1);
    wr(2'd3, 32'd8);

    wr(2'd0, 32'd10); wr(2'd1, 32'd5);
    repeat (30) @(negedge clk);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 32'd1; bus_wr = 1;
    h = 1;
    @(negedge clk); bus_wr = 0; h += int'(pwm_out);
    repeat (8) begin @(negedge clk); h += int'(pwm_out); end
    chk("R4 running period keeps old pulse", h, 5);
    highs(10, h); chk("R4 next period uses new pulse", h, 1);
    wr(2'd0, 32'd4);
    highs(10, h);
    repeat (10) @(negedge clk);
    per = 0;
    highs(12, h); chk("R4 new period applied", h, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule